// File: doc/BRIEF.md
# Programmable Baud Rate Divider

This block turns the system clock into the timing reference for a serial transmitter. The host loads a 16-bit unsigned divisor as two byte writes. One strobe loads the low byte and one strobe loads the high byte. The block then divides the clock by that integer. It drives a baud clock line at sixteen times the serial bit rate. It also drives a one-cycle baud enable that steps the transmitter once per period of that line.

Internally a down-counter runs from the divisor minus one to zero. Each time it reaches zero it reloads from the divisor register. The cycle in which the counter sits at zero is the tick cycle. The baud clock line is low on the tick cycle and on the cycle before it, and high for the rest of the period. A divisor of zero drives the same line as a divisor of one, but it never produces an enable. Master reset clears the counter and the outputs. It leaves the divisor register as it was.

Top module: `baud_div`

## Requirements
- R1: While `rst` is high, and in the first cycle after a reset, `baud_clk` is 0. `baud_en` is 0 while `rst` is high. The first cycle after `rst` falls is a tick cycle.
- R2: `wr_lo` loads `wdata` into divisor bits 7:0 and `wr_hi` loads it into bits 15:8. Each strobe leaves the other byte unchanged. Writes are accepted while `rst` is high, and reset never clears the divisor.
- R3: With divisor 1, `baud_en` is 1 in every cycle after reset and `baud_clk` stays 0.
- R4: With divisor 0, `baud_clk` behaves exactly as with divisor 1 (constant 0) and `baud_en` is never 1.
- R5: With divisor 2, `baud_clk` alternates 0 and 1, one cycle each, giving a 50/50 duty cycle. It is 0 in each tick cycle.
- R6: With divisor n of 3 or more, each n-cycle period has `baud_clk` 0 for 2 cycles (the tick cycle and the cycle before it) and 1 for n-2 cycles.
- R7: For a nonzero divisor n, `baud_en` is a one-cycle pulse that occurs only in tick cycles. Tick cycles are exactly n cycles apart, so for n of 2 or more no two pulses are adjacent.
- R8: A divisor written during operation does not shorten or lengthen the period in progress. It takes effect when the counter next reloads, just after the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous master reset, active high |
| wr_lo | input | 1 | Load `wdata` into the divisor low byte |
| wr_hi | input | 1 | Load `wdata` into the divisor high byte |
| wdata | input | 8 | Divisor byte write data |
| baud_clk | output | 1 | Baud clock line, sixteen times the bit rate |
| baud_en | output | 1 | One-cycle transmitter step pulse |

## Verification
The assertions assume that `rst` is synchronous and that the divisor holds a defined value before `rst` falls. The bench meets this by loading both divisor bytes while reset is held. The assertions also take for granted that the outputs are judged only from the sampled register state, never between edges. The bench drives every strobe and reset change on the falling clock edge and samples just after it. It changes the divisor during a run only in the mid-period test, so the period checks elsewhere see one divisor per run.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;
  localparam int unsigned DIV_W = 16;
  typedef logic [DIV_W-1:0] div_t;

  // Divisor actually used by the counter: zero counts as one.
  function automatic div_t eff_div(input div_t d);
    return (d == '0) ? div_t'(1) : d;
  endfunction

  // Low phase of the baud line for counter value c within a period of n cycles.
  function automatic logic phase_low(input div_t c, input div_t n);
    if (n <= div_t'(1))      return 1'b1;
    else if (n == div_t'(2)) return (c == '0);
    else                     return (c < div_t'(2));
  endfunction
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs
  import baud_div_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned LANES = DIV_W / BYTE_W
) (
  input  logic              clk,
  input  logic [LANES-1:0]  wr_stb,
  input  logic [BYTE_W-1:0] wdata,
  output div_t              div_o
);
  // Divisor byte lanes; deliberately without reset.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (wr_stb[g]) byte_q <= wdata;
    end
    assign div_o[g*BYTE_W +: BYTE_W] = byte_q;
  end
endmodule

// File: rtl/baud_div_core.sv
module baud_div_core
  import baud_div_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  div_t div_i,
  output div_t cnt_o,
  output div_t per_o,
  output div_t cnt_nxt_o,
  output div_t per_nxt_o,
  output logic reload_o
);
  div_t cnt_q, per_q, cnt_d, per_d;

  assign reload_o = (cnt_q == '0);

  always_comb begin
    if (reload_o) begin
      cnt_d = eff_div(div_i) - div_t'(1);
      per_d = eff_div(div_i);
    end else begin
      cnt_d = cnt_q - div_t'(1);
      per_d = per_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      per_q <= div_t'(1);
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign per_o     = per_q;
  assign cnt_nxt_o = cnt_d;
  assign per_nxt_o = per_d;
endmodule

// File: rtl/baud_div_out.sv
module baud_div_out
  import baud_div_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  div_t div_i,
  input  div_t cnt_nxt_i,
  input  div_t per_nxt_i,
  input  logic reload_i,
  output logic baud_clk_o,
  output logic baud_en_o
);
  logic clk_q;

  // Registered line so that it is free of decode glitches.
  always_ff @(posedge clk) begin
    if (rst) clk_q <= 1'b0;
    else     clk_q <= ~phase_low(cnt_nxt_i, per_nxt_i);
  end

  assign baud_clk_o = clk_q;
  assign baud_en_o  = reload_i && (div_i != '0) && !rst;
endmodule

// File: rtl/baud_div.sv
module baud_div
  import baud_div_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic              baud_clk,
  output logic              baud_en
);
  div_t div_q, cnt_q, per_q, cnt_nxt, per_nxt;
  logic reload;

  baud_div_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk    (clk),
    .wr_stb ({wr_hi, wr_lo}),
    .wdata  (wdata),
    .div_o  (div_q)
  );

  baud_div_core u_core (
    .clk       (clk),
    .rst       (rst),
    .div_i     (div_q),
    .cnt_o     (cnt_q),
    .per_o     (per_q),
    .cnt_nxt_o (cnt_nxt),
    .per_nxt_o (per_nxt),
    .reload_o  (reload)
  );

  baud_div_out u_out (
    .clk        (clk),
    .rst        (rst),
    .div_i      (div_q),
    .cnt_nxt_i  (cnt_nxt),
    .per_nxt_i  (per_nxt),
    .reload_i   (reload),
    .baud_clk_o (baud_clk),
    .baud_en_o  (baud_en)
  );
endmodule

// File: rtl/baud_div_chk.sv
module baud_div_chk
  import baud_div_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic baud_clk,
  input logic baud_en,
  input div_t div_q,
  input div_t cnt_q,
  input div_t per_q
);
  // R1: reset clears the counter and the line
  a_r1_reset_state: assert property (@(posedge clk) rst |=> (cnt_q == '0) && !baud_clk);
  // R4: zero divisor never steps the transmitter
  a_r4_zero_no_tick: assert property (@(posedge clk) disable iff (rst)
    (div_q == '0) |-> !baud_en);
  // R3: a one-cycle period ticks every cycle
  a_r3_every_cycle: assert property (@(posedge clk) disable iff (rst)
    ((per_q == div_t'(1)) && (div_q != '0)) |-> baud_en);
  // R5, R6: the line is low whenever a tick is issued
  a_r6_low_on_tick: assert property (@(posedge clk) disable iff (rst)
    baud_en |-> !baud_clk);
  // R7: no back-to-back ticks when the period is two or more
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (baud_en && (per_q >= div_t'(2))) |=> !baud_en);
  // R8: between reloads the counter only steps down
  a_r8_no_early_reload: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - div_t'(1)));
endmodule

bind baud_div baud_div_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .baud_clk (baud_clk),
  .baud_en  (baud_en),
  .div_q    (div_q),
  .cnt_q    (cnt_q),
  .per_q    (per_q)
);

// File: tb/baud_div_tb.sv
module baud_div_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_lo = 1'b0, wr_hi = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic baud_clk, baud_en;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  baud_div u_dut (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(wdata), .baud_clk(baud_clk), .baud_en(baud_en)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_byte(input logic hi, input logic [7:0] v);
    @(negedge clk);
    wdata = v; wr_lo = !hi; wr_hi = hi;
    @(negedge clk);
    wr_lo = 1'b0; wr_hi = 1'b0;
  endtask

  // Hold reset, optionally load a divisor, check R1, release at a falling edge.
  task automatic reset_run(input logic load, input int n);
    @(negedge clk);
    rst = 1'b1;
    if (load) begin
      write_byte(1'b0, n[7:0]);
      write_byte(1'b1, n[15:8]);
    end
    @(negedge clk); @(negedge clk);
    #1;
    check(baud_clk == 1'b0, "R1 clk in reset", baud_clk, 0);
    check(baud_en == 1'b0, "R1 en in reset", baud_en, 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  // Compare each cycle with the period pattern; k = cycles since release.
  task automatic run_pattern(input int n, input int cycles, input string req);
    int ne;
    ne = (n == 0) ? 1 : n;
    for (int k = 0; k < cycles; k++) begin
      int p;
      logic exp_low, exp_en;
      p = k % ne;
      exp_en = (n != 0) && (p == 0);
      if (ne == 1)      exp_low = 1'b1;
      else if (ne == 2) exp_low = (p == 0);
      else              exp_low = (p == 0) || (p == ne - 1);
      check(baud_clk == !exp_low, {req, " baud_clk"}, baud_clk, !exp_low);
      check(baud_en == exp_en, {req, " baud_en"}, baud_en, exp_en);
      @(negedge clk);
      #1;
    end
  endtask

  task automatic t_reset_and_div3();
    reset_run(1'b1, 3);
    run_pattern(3, 12, "R6 n=3 (R1 first tick)");
  endtask

  task automatic t_retention();
    reset_run(1'b1, 4);
    run_pattern(4, 6, "R2 n=4");
    reset_run(1'b0, 0);
    run_pattern(4, 12, "R2 kept over reset");
  endtask

  task automatic t_div1();
    reset_run(1'b1, 1);
    run_pattern(1, 10, "R3 n=1");
  endtask

  task automatic t_div0();
    reset_run(1'b1, 0);
    run_pattern(0, 10, "R4 n=0");
  endtask

  task automatic t_div2();
    reset_run(1'b1, 2);
    run_pattern(2, 12, "R5 n=2");
  endtask

  task automatic t_div7();
    reset_run(1'b1, 7);
    run_pattern(7, 21, "R7 n=7");
  endtask

  task automatic t_large();
    reset_run(1'b1, 259);
    run_pattern(259, 530, "R2 R6 n=259");
    // high byte alone: 259 -> 0x0100 + low byte rewritten to 0
    reset_run(1'b0, 0);
    rst = 1'b1;
    write_byte(1'b0, 8'h00);
    reset_run(1'b0, 0);
    run_pattern(256, 260, "R2 n=256 low byte only");
  endtask

  task automatic t_change();
    reset_run(1'b1, 5);
    // ticks expected at k = 0, 5, 8, 11, 14
    for (int k = 0; k < 16; k++) begin
      logic exp_en;
      exp_en = (k == 0) || (k == 5) || (k == 8) || (k == 11) || (k == 14);
      check(baud_en == exp_en, "R8 change at reload", baud_en, exp_en);
      @(negedge clk);
      if (k == 2) begin
        wdata = 8'd3; wr_lo = 1'b1;
      end else begin
        wr_lo = 1'b0;
      end
      #1;
    end
  endtask

  initial begin
    t_reset_and_div3();
    t_retention();
    t_div1();
    t_div0();
    t_div2();
    t_div7();
    t_large();
    t_change();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule